// File: doc/BRIEF.md
# Indexed CHR Bank Switching Mapper

This block sits on a game cartridge between the console buses and the memory chips. It watches CPU writes into the upper half of the CPU address space. A write to the even address of the lowest 8 KB of that range is an index write: it latches a three-bit pointer to one of eight bank registers. A write to the odd address of the same range is a data write: it loads the pointed-to register with the data byte. Six of the registers hold CHR (pattern table) bank numbers. The other two hold PRG bank numbers.

On the video side, the mapper decodes each pattern-table fetch from the PPU address lines 12 down to 10, with no clock involved. That decode picks the CHR register that supplies CHR address bits 16 down to 10. The lower half of the pattern space is split into two 2 KB windows, and the upper half into four 1 KB windows. On the CPU side, the two PRG registers drive the bank for the two lower 8 KB program windows. The two upper windows are tied to the last two banks of a 512 KB program space.

The register file is clocked by `clk`, which stands for the bus phase edge at which a CPU write is stable. Reset is synchronous and active low.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset, every bank register holds 0. With rst_n low, the index latch is also forced to 0.
- R2: An index write stores cpu_data[2:0] as the register index and ignores the upper data bits. An index write is cpu_rw=0 with cpu_romsel_n=0, cpu_addr[14:13]=00 and cpu_addr[0]=0. An index write alters no bank register.
- R3: A data write has the same qualifiers as an index write but cpu_addr[0]=1. It loads the data byte into the register picked by the last index write. The index persists across any number of data writes.
- R4: A write does nothing to the index or to any register when any of the following holds: cpu_rw=1, cpu_romsel_n=1, cpu_addr[14]=1 or cpu_addr[13]=1.
- R5: PPU addresses $0000–$07FF use register 0 and $0800–$0FFF use register 1. In these 2 KB windows, chr_bank takes bits 6..1 of the register, and bit 0 is ppu_addr[10]. So writing $78 to register 0 places CHR $1E000–$1E7FF at PPU $0000–$07FF.
- R6: PPU $1000, $1400, $1800 and $1C00 each start a 1 KB window, served in that order by registers 2, 3, 4 and 5. chr_bank is the full 7-bit register value, and bit 7 of the data byte is not stored.
- R7: chr_addr_lo always equals ppu_addr[9:0]. chr_ce_n is 0 exactly when ppu_addr[13] is 0.
- R8: prg_bank selects by cpu_addr[14:13] as follows. 00 gives register 6 and 01 gives register 7, each keeping data bits 5..0 only. 10 gives bank 62 and 11 gives bank 63.
- R9: chr_bank follows ppu_addr combinationally, with no clock edge needed. It is independent of the current index value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock (bus phase edge) |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rw | input | 1 | CPU read/write, 0 = write |
| cpu_romsel_n | input | 1 | Low when the CPU addresses $8000–$FFFF |
| cpu_addr | input | 15 | CPU address bits 14..0 |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address bits 13..0 |
| chr_bank | output | 7 | CHR address bits 16..10 |
| chr_addr_lo | output | 10 | CHR address bits 9..0 |
| chr_ce_n | output | 1 | CHR chip enable, active low |
| prg_bank | output | 6 | PRG address bits 18..13 |

## Verification
The first full sweep of every PPU address runs with all registers at zero. Later sweeps use distinct values in each register, including values with bit 7 and bit 0 set. These sweeps tell apart the 2 KB pair windows from the 1 KB windows, and catch a swapped register order. Writing $78 to register 0 pins the pair window's low-bit substitution. Writes that each break a single qualifier (read, ROM select high, A14 or A13 set) are followed by probes of the register they would have hit. These show that each qualifier is decoded on its own. A run of pseudo-random write sequences, each followed by a sweep, exercises index persistence and the fixed PRG windows.

// File: rtl/mapper_pkg.sv
// Package: shared sizes and types for the CHR bank switching mapper.
// Assumes eight registers addressed by a three-bit index, six CHR then two PRG.
package mapper_pkg;
    localparam int DATA_W   = 8;
    localparam int CHR_W    = 7;
    localparam int PRG_W    = 6;
    localparam int NUM_CHR  = 6;
    localparam int NUM_PRG  = 2;
    localparam int NUM_REGS = NUM_CHR + NUM_PRG;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int REG_W    = (CHR_W > PRG_W) ? CHR_W : PRG_W;
    localparam int CPU_AW   = 15;
    localparam int PPU_AW   = 14;
    localparam int PAGE_W   = 10;

    typedef logic [REG_W-1:0] bank_t;
endpackage

// File: rtl/mapper_cpu_decode.sv
// Module: CPU write decoder and register-index latch.
// Qualifies writes into the lowest 8 KB of the ROM range. An even address
// latches the index; an odd address produces a one-hot load strobe.
// Assumes clk marks the point where the CPU write data is stable.
module mapper_cpu_decode
    import mapper_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_rw,
    input  logic                cpu_romsel_n,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_data,
    output logic [NUM_REGS-1:0] load_en
);
    logic             wr_ok;
    logic             idx_wr;
    logic             dat_wr;
    logic [SEL_W-1:0] idx_q;

    // Qualify a write into the index/data window.
    always_comb begin
        wr_ok  = !cpu_rw && !cpu_romsel_n && (cpu_addr[CPU_AW-1 -: 2] == 2'b00);
        idx_wr = wr_ok && !cpu_addr[0];
        dat_wr = wr_ok &&  cpu_addr[0];
    end

    // Hold the register index from the last index write.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= cpu_data[SEL_W-1:0];
    end

    // Turn a data write into a one-hot load strobe.
    always_comb begin
        load_en = '0;
        if (dat_wr) load_en[idx_q] = 1'b1;
    end

    logic unused_bits;
    assign unused_bits = ^{cpu_addr[CPU_AW-3:1], cpu_data[DATA_W-1:SEL_W]};
endmodule

// File: rtl/mapper_regfile.sv
// Module: bank register file.
// Each register loads on its strobe. CHR registers keep CHR_W data bits and
// PRG registers keep PRG_W bits. Unused upper bits read as zero.
module mapper_regfile
    import mapper_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            load_en,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int KEEP = (i < NUM_CHR) ? CHR_W : PRG_W;
        logic [KEEP-1:0] val_q;

        // Load this register on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          val_q <= '0;
            else if (load_en[i]) val_q <= wdata[KEEP-1:0];
        end

        if (KEEP < REG_W) begin : g_pad
            assign regs_q[i] = {{(REG_W-KEEP){1'b0}}, val_q};
        end else begin : g_full
            assign regs_q[i] = val_q;
        end
    end

    logic unused_data;
    assign unused_data = ^wdata[DATA_W-1:CHR_W];
endmodule

// File: rtl/mapper_chr_mux.sv
// Module: CHR window multiplexer.
// Selects a CHR register from PPU A12..A10 with no clock. The lower half of
// pattern space is two 2 KB windows (register LSB replaced by A10); the upper
// half is four 1 KB windows.
module mapper_chr_mux
    import mapper_pkg::*;
(
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs_q,
    input  logic [PPU_AW-1:0]              ppu_addr,
    output logic [CHR_W-1:0]               chr_bank,
    output logic [PAGE_W-1:0]              chr_addr_lo,
    output logic                           chr_ce_n
);
    localparam int SEG_LSB = PAGE_W;
    logic             a12, a11, a10;
    logic [REG_W-1:0] pair_reg;
    logic [SEL_W-1:0] one_idx;

    // Split the PPU address into window select bits.
    always_comb begin
        a10 = ppu_addr[SEG_LSB];
        a11 = ppu_addr[SEG_LSB+1];
        a12 = ppu_addr[SEG_LSB+2];
    end

    // Pick the window register and form the CHR bank.
    always_comb begin
        pair_reg = a11 ? regs_q[1] : regs_q[0];
        one_idx  = SEL_W'(2) + SEL_W'({a11, a10});
        if (!a12) chr_bank = {pair_reg[CHR_W-1:1], a10};
        else      chr_bank = regs_q[one_idx][CHR_W-1:0];
    end

    // Pass the page offset through and enable CHR below $2000.
    always_comb begin
        chr_addr_lo = ppu_addr[PAGE_W-1:0];
        chr_ce_n    = ppu_addr[PPU_AW-1];
    end

    logic unused_regs;
    assign unused_regs = ^{regs_q[NUM_REGS-1], regs_q[NUM_REGS-2], pair_reg[0]};
endmodule

// File: rtl/mapper_prg_mux.sv
// Module: PRG window multiplexer.
// The two lower 8 KB windows come from the PRG registers. The two upper
// windows are fixed to the second-to-last and last bank.
module mapper_prg_mux
    import mapper_pkg::*;
(
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs_q,
    input  logic [1:0]                     win,
    output logic [PRG_W-1:0]               prg_bank
);
    localparam logic [PRG_W-1:0] LAST_BANK = '1;
    localparam logic [PRG_W-1:0] PREV_BANK = LAST_BANK - PRG_W'(1);

    // Map the CPU window to its bank number.
    always_comb begin
        case (win)
            2'b00:   prg_bank = regs_q[NUM_CHR][PRG_W-1:0];
            2'b01:   prg_bank = regs_q[NUM_CHR+1][PRG_W-1:0];
            2'b10:   prg_bank = PREV_BANK;
            default: prg_bank = LAST_BANK;
        endcase
    end

    logic unused_regs;
    assign unused_regs = ^{regs_q[NUM_CHR-1:0], regs_q[NUM_CHR][REG_W-1:PRG_W],
                           regs_q[NUM_CHR+1][REG_W-1:PRG_W]};
endmodule

// File: rtl/chr_bank_mapper.sv
// Module: top of the indexed CHR bank switching mapper.
// Connects the write decoder, register file, CHR window mux and PRG mux.
// Assumes all CPU write qualifiers are stable at the rising edge of clk.
module chr_bank_mapper
    import mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rw,
    input  logic              cpu_romsel_n,
    input  logic [14:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic [13:0]       ppu_addr,
    output logic [6:0]        chr_bank,
    output logic [9:0]        chr_addr_lo,
    output logic              chr_ce_n,
    output logic [5:0]        prg_bank
);
    logic [NUM_REGS-1:0]            load_en;
    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

    mapper_cpu_decode u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_rw       (cpu_rw),
        .cpu_romsel_n (cpu_romsel_n),
        .cpu_addr     (cpu_addr),
        .cpu_data     (cpu_data),
        .load_en      (load_en)
    );

    mapper_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .wdata   (cpu_data),
        .regs_q  (regs_q)
    );

    mapper_chr_mux u_chr (
        .regs_q      (regs_q),
        .ppu_addr    (ppu_addr),
        .chr_bank    (chr_bank),
        .chr_addr_lo (chr_addr_lo),
        .chr_ce_n    (chr_ce_n)
    );

    mapper_prg_mux u_prg (
        .regs_q   (regs_q),
        .win      (cpu_addr[CPU_AW-1 -: 2]),
        .prg_bank (prg_bank)
    );
endmodule

// File: rtl/chr_bank_mapper_checker.sv
// Module: assertion checker for the mapper, bound to the top module.
// Only observes ports. A short warm-up counter keeps history checks away
// from pre-reset values.
module chr_bank_mapper_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_rw,
    input logic        cpu_romsel_n,
    input logic [14:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic [13:0] ppu_addr,
    input logic [6:0]  chr_bank,
    input logic [9:0]  chr_addr_lo,
    input logic        chr_ce_n,
    input logic [5:0]  prg_bank
);
    logic [1:0] warm_q;
    logic       live;

    // Count cycles since reset so history checks start cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    assign live = (warm_q == 2'd3);

    logic unused_in;
    assign unused_in = ^cpu_data;

    // R4: a cycle without a write leaves the CHR mapping unchanged
    a_r4_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (cpu_rw || cpu_romsel_n)) ##1 $stable(ppu_addr) |-> $stable(chr_bank));

    // R4: writes above the index window leave PRG mapping unchanged
    a_r4_high_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (cpu_addr[14:13] != 2'b00)) ##1 $stable(cpu_addr) |-> $stable(prg_bank));

    // R2: an index write alters no bank register
    a_r2_index_no_bank_change: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !cpu_rw && !cpu_romsel_n && !cpu_addr[0]) ##1 $stable(ppu_addr) |-> $stable(chr_bank));

    // R5: in a 2 KB window the bank LSB follows PPU A10
    a_r5_pair_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_addr[12] |-> (chr_bank[0] == ppu_addr[10]));

    // R7: CHR enable tracks the pattern region
    a_r7_ce_nametable: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_addr[13] |-> chr_ce_n);
    a_r7_ce_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_addr[13] |-> !chr_ce_n);

    // R7: page offset passes straight through
    a_r7_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr_lo == ppu_addr[9:0]);

    // R8: upper PRG windows are fixed
    a_r8_fixed_prev: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b10) |-> (prg_bank == 6'd62));
    a_r8_fixed_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (prg_bank == 6'd63));
endmodule

bind chr_bank_mapper chr_bank_mapper_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_rw       (cpu_rw),
    .cpu_romsel_n (cpu_romsel_n),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .ppu_addr     (ppu_addr),
    .chr_bank     (chr_bank),
    .chr_addr_lo  (chr_addr_lo),
    .chr_ce_n     (chr_ce_n),
    .prg_bank     (prg_bank)
);

// File: tb/chr_bank_mapper_tb_top.sv
// Bench: drives CPU writes, keeps an arithmetic model of the registers and
// sweeps the PPU address space, comparing every output.
module chr_bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rw = 1'b1;
    logic        cpu_romsel_n = 1'b1;
    logic [14:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [6:0]  chr_bank;
    logic [9:0]  chr_addr_lo;
    logic        chr_ce_n;
    logic [5:0]  prg_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_reg [8];
    int m_idx;

    always #5 clk = ~clk;

    chr_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rw(cpu_rw), .cpu_romsel_n(cpu_romsel_n),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .ppu_addr(ppu_addr),
        .chr_bank(chr_bank), .chr_addr_lo(chr_addr_lo), .chr_ce_n(chr_ce_n),
        .prg_bank(prg_bank)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_chr(input int a);
        int sel;
        sel = (a >> 10) & 3;
        if (((a >> 12) & 1) == 0)
            return (m_reg[sel >> 1] & 'h7E) | (sel & 1);
        return m_reg[2 + sel];
    endfunction

    // Model a bus write per R2, R3, R4.
    task automatic model_write(input int a, input int d, input bit rw, input bit rs);
        if (!rw && !rs && ((a >> 13) & 3) == 0) begin
            if ((a & 1) == 0) m_idx = d & 7;
            else m_reg[m_idx] = (m_idx < 6) ? (d & 'h7F) : (d & 'h3F);
        end
    endtask

    task automatic bus_write(input int a, input int d, input bit rw, input bit rs);
        @(negedge clk);
        cpu_addr = a[14:0]; cpu_data = d[7:0]; cpu_rw = rw; cpu_romsel_n = rs;
        @(negedge clk);
        cpu_rw = 1'b1; cpu_romsel_n = 1'b1;
        model_write(a, d, rw, rs);
    endtask

    task automatic set_reg(input int r, input int d);
        bus_write('h0000, 'hF8 | r, 1'b0, 1'b0);
        bus_write('h0001, d, 1'b0, 1'b0);
    endtask

    // Full PPU sweep: R5, R6 bank, R7 enable/offset, R9 no clock needed.
    task automatic sweep(input string tag);
        for (int a = 0; a < 16384; a++) begin
            ppu_addr = a[13:0];
            #1;
            if (a < 'h2000) begin
                if (a < 'h1000) check({"R5 ", tag}, int'(chr_bank), exp_chr(a));
                else            check({"R6 ", tag}, int'(chr_bank), exp_chr(a));
            end
            if ((a & 'hFF) == 'h5A) begin
                check("R7 offset", int'(chr_addr_lo), a & 'h3FF);
                check("R7 enable", int'(chr_ce_n), (a >> 13) & 1);
            end
        end
    endtask

    task automatic check_prg(input string tag);
        for (int w = 0; w < 4; w++) begin
            cpu_addr = 15'(w << 13);
            #1;
            check({"R8 ", tag}, int'(prg_bank),
                  (w == 0) ? m_reg[6] : (w == 1) ? m_reg[7] : (w == 2) ? 62 : 63);
        end
        cpu_addr = '0;
    endtask

    task automatic probe(input string tag, input int a);
        ppu_addr = a[13:0];
        #1;
        check(tag, int'(chr_bank), exp_chr(a));
    endtask

    initial begin
        int lfsr;
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
        m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state everywhere
        sweep("R1 reset");
        check_prg("R1 reset");

        // R5: $78 in register 0 maps CHR $1E000 at PPU $0000
        set_reg(0, 'h78);
        probe("R5 pair lo", 'h0000);
        check("R5 bank78", int'(chr_bank), 'h78);
        probe("R5 pair hi", 'h0400);
        check("R5 bank79", int'(chr_bank), 'h79);

        // R6, R8: distinct values with high bits set
        for (int r = 0; r < 8; r++) set_reg(r, 'h80 | (r * 'h13 + 5));
        sweep("distinct");
        check_prg("distinct");

        // R4: each qualifier broken alone, aimed at register 2
        bus_write('h0000, 2, 1'b0, 1'b0);
        bus_write('h0001, 'h11, 1'b1, 1'b0);
        probe("R4 read ignored", 'h1000);
        bus_write('h0001, 'h22, 1'b0, 1'b1);
        probe("R4 romsel ignored", 'h1000);
        bus_write('h4001, 'h33, 1'b0, 1'b0);
        probe("R4 a14 ignored", 'h1000);
        bus_write('h2001, 'h44, 1'b0, 1'b0);
        probe("R4 a13 ignored", 'h1000);
        bus_write('h2000, 5, 1'b0, 1'b0);
        bus_write('h0001, 'h2A, 1'b0, 1'b0);
        probe("R4 index kept", 'h1000);
        check("R4 reg2 value", int'(chr_bank), 'h2A);
        probe("R4 reg5 untouched", 'h1C00);
        bus_write('h6000, 'h3F, 1'b0, 1'b0);
        check_prg("R4 prg");

        // R3: index persists across several data writes
        bus_write('h0000, 4, 1'b0, 1'b0);
        bus_write('h0001, 'h10, 1'b0, 1'b0);
        bus_write('h0001, 'h6D, 1'b0, 1'b0);
        probe("R3 persist", 'h1800);
        check("R3 last value", int'(chr_bank), 'h6D);

        // R2, R9: index write alone changes no mapping
        bus_write('h0000, 'hF9, 1'b0, 1'b0);
        sweep("R9 after index");

        // Pseudo-random write sequences
        lfsr = 'hACE1;
        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < 12; k++) begin
                lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
                bus_write((lfsr & 1) | (((lfsr >> 9) & 1) ? 'h2000 : 0),
                          (lfsr >> 3) & 'hFF, 1'b0, 1'b0);
            end
            sweep("R3 random");
            check_prg("random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule